// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one burst request into the column addresses a synchronous DRAM would walk through, one address per clock. A request is a one-cycle start strobe that carries a starting column, a burst-length code and an ordering bit. The block answers with a column, a valid flag and a last flag. In full-page mode it keeps going until a terminate input cuts the burst short.

Two orderings are supported. Sequential ordering counts the low bits of the column upward and wraps them inside a block aligned to the burst length. Interleaved ordering XORs the low bits of the starting column with the beat number. A full-page burst walks the whole page with sequential ordering and wraps from the top column back to column 0. Asking for full page with interleaved ordering, or using a reserved length code, raises a configuration-error pulse, and no burst is produced. The block only computes addresses. It issues no commands and moves no data.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, and until the first start, valid_o, last_o and cfg_err_o are low.
- R2: When start_i is sampled high with a legal configuration, valid_o is high on the next cycle and col_o equals start_col_i.
- R3: bl_code_i selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8 and 7 gives full page. A fixed-length burst gives exactly that many consecutive valid beats, after which valid_o falls.
- R4: When burst_type_i is 0 (sequential), beat i carries the start column with its low log2(BL) bits replaced by (start + i) mod BL. The upper bits stay at their start values.
- R5: When burst_type_i is 1 (interleaved), beat i carries the start column with its low log2(BL) bits XORed with i.
- R6: A full-page burst gives column (start + i) mod 256 on beat i and wraps from 255 to 0. It runs until it is terminated.
- R7: In a full-page burst, term_i high during a valid beat makes last_o high in that same cycle. valid_o is low on the next cycle unless a new start was given.
- R8: term_i has no effect on a fixed-length burst: the columns, the last flag and the length stay unchanged.
- R9: In a fixed-length burst, last_o is high on the final beat and on no other beat. last_o is never high without valid_o.
- R10: A start with full page and interleaved ordering, or with length code 4, 5 or 6, makes cfg_err_o high for exactly the next cycle. It produces no valid beat and ends any burst in progress.
- R11: A start during a running burst abandons that burst. The next cycle shows beat 0 of the new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle burst request |
| start_col_i | input | 8 | Starting column |
| bl_code_i | input | 3 | Burst length code |
| burst_type_i | input | 1 | 0 sequential, 1 interleaved |
| term_i | input | 1 | Ends a full-page burst on the current beat |
| col_o | output | 8 | Column for the current beat |
| valid_o | output | 1 | A beat is present this cycle |
| last_o | output | 1 | Final beat of the burst |
| cfg_err_o | output | 1 | Illegal configuration pulse |

## Verification
The bench builds the block with its default 8-bit column, which gives a 256-column page. At that size a full-page burst that runs past column 255 and wraps to 0 takes only a few hundred cycles, so the wrap can be tested directly. With 8-bit columns, every fixed length up to 8 and the aligned-block wrap near the top of the page can be exercised, under both orderings and from starting columns that are not aligned.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [2:0] {
    BLC_1    = 3'd0,
    BLC_2    = 3'd1,
    BLC_4    = 3'd2,
    BLC_8    = 3'd3,
    BLC_PAGE = 3'd7
  } bl_code_e;

  typedef enum logic {
    ORD_SEQ  = 1'b0,
    ORD_INTL = 1'b1
  } order_e;
endpackage

// File: rtl/burst_cfg_decode.sv
module burst_cfg_decode #(
  parameter int COL_W = 8
) (
  input  logic [2:0]       bl_code_i,
  input  logic             order_i,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o,
  output logic             illegal_o
);
  import burst_seq_pkg::*;

  always_comb begin
    mask_o    = '0;
    full_o    = 1'b0;
    illegal_o = 1'b0;
    case (bl_code_i)
      BLC_1:    mask_o = '0;
      BLC_2:    mask_o = COL_W'(1);
      BLC_4:    mask_o = COL_W'(3);
      BLC_8:    mask_o = COL_W'(7);
      BLC_PAGE: begin
        mask_o = '1;
        full_o = 1'b1;
      end
      default:  illegal_o = 1'b1;
    endcase
    // full page only walks sequentially
    if (full_o && (order_i == ORD_INTL)) illegal_o = 1'b1;
  end
endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl #(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cfg_ok_i,
  input  logic             full_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             term_i,
  output logic             active_o,
  output logic [COL_W-1:0] beat_o,
  output logic [COL_W-1:0] mask_o,
  output logic             last_o
);
  logic             active_q;
  logic             full_q;
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] mask_q;

  assign last_o = active_q & (full_q ? term_i : (beat_q == mask_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      full_q   <= 1'b0;
      beat_q   <= '0;
      mask_q   <= '0;
    end else if (start_i) begin
      active_q <= cfg_ok_i;
      full_q   <= full_i;
      beat_q   <= '0;
      mask_q   <= mask_i;
    end else if (active_q) begin
      if (last_o) active_q <= 1'b0;
      else        beat_q   <= beat_q + COL_W'(1);
    end
  end

  assign active_o = active_q;
  assign beat_o   = beat_q;
  assign mask_o   = mask_q;

  // R3
  beat_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !full_q) |-> (beat_q <= mask_q));

  // R7
  term_ends_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && full_q && term_i && !start_i) |=> !active_q);
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             order_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  output logic             order_o,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] base_q;
  logic             order_q;
  logic [COL_W-1:0] seq_low;
  logic [COL_W-1:0] intl_low;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      order_q <= 1'b0;
    end else if (start_i) begin
      base_q  <= col_i;
      order_q <= order_i;
    end
  end

  assign seq_low  = base_q + beat_i;
  assign intl_low = base_q ^ beat_i;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col_o[b] = mask_i[b] ? (order_q ? intl_low[b] : seq_low[b]) : base_q[b];
  end

  assign order_o = order_q;
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       bl_code_i,
  input  logic             burst_type_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             cfg_err_o
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_full;
  logic             dec_illegal;
  logic             active;
  logic [COL_W-1:0] beat;
  logic [COL_W-1:0] mask_q;
  logic             order_q;
  logic             err_q;

  burst_cfg_decode #(.COL_W(COL_W)) u_dec (
    .bl_code_i (bl_code_i),
    .order_i   (burst_type_i),
    .mask_o    (dec_mask),
    .full_o    (dec_full),
    .illegal_o (dec_illegal)
  );

  burst_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .cfg_ok_i (!dec_illegal),
    .full_i   (dec_full),
    .mask_i   (dec_mask),
    .term_i   (term_i),
    .active_o (active),
    .beat_o   (beat),
    .mask_o   (mask_q),
    .last_o   (last_o)
  );

  burst_addr_gen #(.COL_W(COL_W)) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .col_i   (start_col_i),
    .order_i (burst_type_i),
    .beat_i  (beat),
    .mask_i  (mask_q),
    .order_o (order_q),
    .col_o   (col_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= start_i & dec_illegal;
  end

  assign valid_o   = active;
  assign cfg_err_o = err_q;

  // R9
  last_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);

  // R10
  err_no_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !valid_o);

  // R2
  first_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !dec_illegal) |=> (valid_o && col_o == $past(start_col_i)));

  // R4
  upper_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o) && !$past(last_o) && !$past(start_i))
      |-> (((col_o ^ $past(col_o)) & ~mask_q) == '0));

  // R4
  seq_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !order_q && $past(valid_o) && !$past(last_o) && !$past(start_i))
      |-> (((col_o - $past(col_o)) & mask_q) == COL_W'(1)));
endmodule

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] start_col_i = '0;
  logic [2:0] bl_code_i = '0;
  logic       burst_type_i = 1'b0;
  logic       term_i = 1'b0;
  logic [7:0] col_o;
  logic       valid_o, last_o, cfg_err_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  burst_col_seq u_burst_col_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .start_col_i(start_col_i),
    .bl_code_i(bl_code_i), .burst_type_i(burst_type_i), .term_i(term_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .cfg_err_o(cfg_err_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_col(input logic [7:0] s, input int len,
                                         input bit intl, input int i);
    logic [7:0] m;
    m = 8'(len - 1);
    if (intl) return (s & ~m) | ((s ^ 8'(i)) & m);
    return (s & ~m) | ((s + 8'(i)) & m);
  endfunction

  task automatic issue(input logic [7:0] s, input logic [2:0] code, input bit intl);
    start_i = 1'b1; start_col_i = s; bl_code_i = code; burst_type_i = intl;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  // R1
  task automatic t_reset();
    check(!valid_o && !last_o && !cfg_err_o, "R1 reset outputs",
          {valid_o, last_o, cfg_err_o}, 0);
  endtask

  // R2 R3 R4 R5 R8 R9
  task automatic t_fixed(input logic [7:0] s, input logic [2:0] code, input bit intl,
                         input bit poke_term);
    int len;
    len = 1 << code;
    issue(s, code, intl);
    for (int i = 0; i < len; i++) begin
      term_i = poke_term;
      #0;
      check(valid_o, "R3 valid during burst", valid_o, 1);
      check(col_o == exp_col(s, len, intl, i), intl ? "R5 interleaved column" : "R4 sequential column",
            col_o, exp_col(s, len, intl, i));
      check(last_o == (i == len - 1), poke_term ? "R8 last with term" : "R9 last on final beat",
            last_o, i == len - 1);
      @(negedge clk_i);
    end
    term_i = 1'b0;
    check(!valid_o, "R3 burst ends after BL beats", valid_o, 0);
  endtask

  // R6 R7
  task automatic t_page(input logic [7:0] s, input int n);
    issue(s, 3'd7, 1'b0);
    for (int i = 0; i < n; i++) begin
      term_i = (i == n - 1);
      #0;
      check(valid_o && col_o == 8'(s + 8'(i)), "R6 full page column", col_o, 8'(s + 8'(i)));
      check(last_o == (i == n - 1), "R7 last on terminate", last_o, i == n - 1);
      @(negedge clk_i);
    end
    term_i = 1'b0;
    check(!valid_o, "R7 page ends after terminate", valid_o, 0);
  endtask

  // R10
  task automatic t_illegal(input logic [2:0] code, input bit intl);
    issue(8'h40, 3'd3, 1'b0);
    @(negedge clk_i);
    issue(8'h21, code, intl);
    check(cfg_err_o == 1'b1, "R10 error pulse", cfg_err_o, 1);
    check(!valid_o, "R10 no beat and burst aborted", valid_o, 0);
    @(negedge clk_i);
    check(!cfg_err_o && !valid_o, "R10 error one cycle", {cfg_err_o, valid_o}, 0);
  endtask

  // R11
  task automatic t_restart();
    issue(8'h10, 3'd2, 1'b0);
    @(negedge clk_i);
    t_fixed(8'hA5, 3'd3, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_fixed(8'h37, 3'd0, 1'b0, 1'b0);
    t_fixed(8'h37, 3'd1, 1'b0, 1'b0);
    t_fixed(8'h36, 3'd2, 1'b0, 1'b0);
    t_fixed(8'hFD, 3'd3, 1'b0, 1'b0);
    t_fixed(8'h5B, 3'd2, 1'b1, 1'b0);
    t_fixed(8'h9E, 3'd3, 1'b1, 1'b0);
    t_fixed(8'h13, 3'd1, 1'b1, 1'b0);
    t_fixed(8'hC2, 3'd3, 1'b0, 1'b1);
    t_fixed(8'h0D, 3'd2, 1'b1, 1'b1);
    t_page(8'hF0, 300);
    t_page(8'h02, 1);
    t_illegal(3'd7, 1'b1);
    t_illegal(3'd5, 1'b0);
    t_restart();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule